// File: doc/BRIEF.md
# Prescaled Up-Counting Timer

This block is the time base of a general timer peripheral. A programmable prescaler divides the block clock, and each prescaler wrap advances an up-counter. The counter climbs from zero to a programmable limit, returns to zero and signals an update event on that step. The update event sets a sticky flag. When software enables it, the flag drives a level interrupt request. The block ticks once every (prescale + 1) x (limit + 1) enabled clock cycles. For example, a prescale value of 8399 and a limit of 999 on an 84 MHz clock give one update every 8,400,000 cycles, which is 100 ms.

Software reaches six registers through a simple synchronous bus that has an address, a write strobe, write data and read data. A write takes effect at the clock edge on which the strobe is high. Read data is a combinational function of the address and shows the current register contents in the same cycle. Register offsets are 0x00 run control, 0x04 interrupt enable, 0x08 status, 0x0C counter, 0x10 prescale and 0x14 limit. All fields sit at bit 0 and read back zero-extended.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, the registers read as follows. Run control, interrupt enable, status, counter and prescale read 0. The limit reads all ones (0xFFFF for 16 bits). The interrupt output is low.
- R2: With prescale value P, the counter advances exactly once every P+1 enabled clock cycles. The prescaler's internal count starts at 0 after reset.
- R3: The counter steps 0, 1, ... up to the limit value L, then returns to 0. The step from L to 0 is an update event. Starting from a prescaler count of 0 and counter 0, the first update lands on enabled cycle (P+1)(L+1).
- R4: Bit 0 of run control (offset 0x00) enables counting. While it is 0, the counter and the internal prescaler count both hold their values. Counting resumes from the held state.
- R5: Bit 0 of status (offset 0x08) is the update flag. Hardware sets it on every update event, and it stays set. Writing a 0 to bit 0 clears it. Writing a 1 leaves it unchanged.
- R6: If an update event and a software clear of the flag fall in the same cycle, the flag ends up set.
- R7: The interrupt output is high exactly while the update flag and bit 0 of interrupt enable (offset 0x04) are both 1. It is a level and follows either bit as soon as that bit changes.
- R8: The counter (0x0C), prescale (0x10) and limit (0x14) registers can be written and read back. A counter write loads the written value at that edge and takes precedence over counting.
- R9: Both wrap checks use "greater than or equal". A counter loaded above the limit returns to 0 with an update event on its next step. A prescaler count left above a newly lowered prescale value wraps on the next enabled cycle.
- R10: Addresses outside the six offsets read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register |
| irq | output | 1 | Level interrupt request: update flag AND interrupt enable |

## Verification
The bench drives a flag clear onto the same edge as an update. A design that lets the clear win would lose the event, and the status would read 0. The bench also leaves the counter above the limit, and the internal prescaler count above a newly lowered prescale value. An equality-only compare would then run through the whole counter range instead of wrapping at once, so the counter would read one step short. A full 200-cycle period is measured to the exact edge, which exposes any off-by-one in either divider stage. The bench also idles with counting disabled and writes a 1 to the status bit. A design that leaked a count, or set the flag on that write, would show a changed counter or status value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register byte offsets; all fields live at bit 0
    localparam int unsigned OFS_RUN  = 32'h00;
    localparam int unsigned OFS_IEN  = 32'h04;
    localparam int unsigned OFS_STAT = 32'h08;
    localparam int unsigned OFS_CNT  = 32'h0C;
    localparam int unsigned OFS_PSC  = 32'h10;
    localparam int unsigned OFS_LIM  = 32'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RUN,
        SEL_IEN,
        SEL_STAT,
        SEL_CNT,
        SEL_PSC,
        SEL_LIM
    } reg_sel_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // >= so a count stranded above a lowered divisor wraps at once
        tick_o  = run_i && (state_q.cnt >= div_i);
        if (run_i) begin
            if (tick_o) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R4
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(state_q.cnt))
        else $error("prescaler count moved while stopped");

    // R2
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (state_q.cnt == '0))
        else $error("prescaler did not restart after tick");

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        ovf_o   = tick_i && (state_q.cnt >= limit_i);
        if (wr_i) begin
            state_d.cnt = wdata_i;
        end else if (tick_i) begin
            if (ovf_o) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !wr_i) |=> (cnt_o == '0))
        else $error("counter did not return to zero on update");

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(cnt_o))
        else $error("counter moved without a tick");

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)))
        else $error("counter load lost");

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ovf_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              run_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [CNT_W-1:0]  lim_o,
    output logic              cnt_wr_o,
    output logic [CNT_W-1:0]  cnt_wdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic             run;
        logic             ien;
        logic             flag;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] lim;
    } reg_state_t;

    reg_state_t state_d, state_q;
    reg_sel_e   sel;
    logic       clr_hit;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        if (addr_i == ADDR_W'(OFS_RUN)) begin
            sel = SEL_RUN;
        end else if (addr_i == ADDR_W'(OFS_IEN)) begin
            sel = SEL_IEN;
        end else if (addr_i == ADDR_W'(OFS_STAT)) begin
            sel = SEL_STAT;
        end else if (addr_i == ADDR_W'(OFS_CNT)) begin
            sel = SEL_CNT;
        end else if (addr_i == ADDR_W'(OFS_PSC)) begin
            sel = SEL_PSC;
        end else if (addr_i == ADDR_W'(OFS_LIM)) begin
            sel = SEL_LIM;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        state_d = state_q;
        clr_hit = we_i && (sel == SEL_STAT) && !wdata_i[0];
        if (we_i) begin
            case (sel)
                SEL_RUN: state_d.run = wdata_i[0];
                SEL_IEN: state_d.ien = wdata_i[0];
                SEL_PSC: state_d.psc = wdata_i[PSC_W-1:0];
                SEL_LIM: state_d.lim = wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        // hardware set outranks a same-cycle software clear
        state_d.flag = ovf_i | (state_q.flag & ~clr_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.lim  <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_RUN:  rdata_o = DATA_W'(state_q.run);
            SEL_IEN:  rdata_o = DATA_W'(state_q.ien);
            SEL_STAT: rdata_o = DATA_W'(state_q.flag);
            SEL_CNT:  rdata_o = DATA_W'(cnt_i);
            SEL_PSC:  rdata_o = DATA_W'(state_q.psc);
            SEL_LIM:  rdata_o = DATA_W'(state_q.lim);
            default:  rdata_o = '0;
        endcase
    end

    assign run_o       = state_q.run;
    assign psc_o       = state_q.psc;
    assign lim_o       = state_q.lim;
    assign cnt_wr_o    = we_i && (sel == SEL_CNT);
    assign cnt_wdata_o = wdata_i[CNT_W-1:0];
    assign irq_o       = state_q.flag & state_q.ien;

    // R6
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> state_q.flag)
        else $error("update event did not set the flag");

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.flag && !(we_i && (addr_i == ADDR_W'(OFS_STAT)) && !wdata_i[0]))
            |=> state_q.flag)
        else $error("flag dropped without a clear");

    // R5
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.flag) |-> $past(ovf_i))
        else $error("flag rose without an update event");

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             run;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] lim_val;
    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;

    tmr_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PSC_W  (PSC_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (bus_addr),
        .we_i        (bus_we),
        .wdata_i     (bus_wdata),
        .rdata_o     (bus_rdata),
        .ovf_i       (ovf),
        .cnt_i       (cnt_val),
        .run_o       (run),
        .psc_o       (psc_val),
        .lim_o       (lim_val),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata),
        .irq_o       (irq)
    );

    tmr_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (psc_val),
        .tick_o (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (cnt_wr),
        .wdata_i (cnt_wdata),
        .limit_i (lim_val),
        .cnt_o   (cnt_val),
        .ovf_o   (ovf)
    );

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ovf) || $past(bus_we && (bus_addr == ADDR_W'(OFS_IEN)))))
        else $error("interrupt rose without flag set or enable write");

endmodule

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;

    localparam logic [7:0] A_RUN = 8'h00, A_IEN = 8'h04, A_STAT = 8'h08;
    localparam logic [7:0] A_CNT = 8'h0C, A_PSC = 8'h10, A_LIM = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    // bench model of the time base, built from the requirements
    int unsigned m_p = 0, m_l = 32'hFFFF, m_psc = 0, m_cnt = 0;
    bit          m_flag = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    tmr_timebase u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                             it.req, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.req = req;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic exp_irq(input bit e, input string req);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.addr = 8'hFF; it.exp = {31'd0, e}; it.req = req;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic model_step();
        if (m_psc >= m_p) begin
            m_psc = 0;
            if (m_cnt >= m_l) begin
                m_cnt  = 0;
                m_flag = 1'b1;
            end else begin
                m_cnt++;
            end
        end else begin
            m_psc++;
        end
    endtask

    // exactly k enabled clock edges (k >= 1)
    task automatic run_edges(input int k);
        wr(A_RUN, 32'd1);
        repeat (k - 1) @(posedge clk);
        wr(A_RUN, 32'd0);
        for (int i = 0; i < k; i++) model_step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        exp_reg(A_RUN, 32'd0, "R1");
        exp_reg(A_IEN, 32'd0, "R1");
        exp_reg(A_STAT, 32'd0, "R1");
        exp_reg(A_CNT, 32'd0, "R1");
        exp_reg(A_PSC, 32'd0, "R1");
        exp_reg(A_LIM, 32'h0000FFFF, "R1");
        exp_irq(1'b0, "R1");

        // R8 read/write of counter, prescale, limit
        wr(A_PSC, 32'd3); m_p = 3;
        wr(A_LIM, 32'd4); m_l = 4;
        wr(A_CNT, 32'd2); m_cnt = 2;
        exp_reg(A_PSC, 32'd3, "R8");
        exp_reg(A_LIM, 32'd4, "R8");
        exp_reg(A_CNT, 32'd2, "R8");

        // R2 one step per P+1 cycles: 7 edges at P=3 give one step
        wr(A_CNT, 32'd0); m_cnt = 0;
        run_edges(7);
        exp_reg(A_CNT, 32'd1, "R2");

        // R3 wrap at limit: 13 more edges reach 4 then 0 with update
        run_edges(13);
        exp_reg(A_CNT, 32'd0, "R3");
        exp_reg(A_STAT, 32'd1, "R3");
        exp_irq(1'b0, "R7");

        // R5 write 1 keeps, write 0 clears
        wr(A_STAT, 32'd1);
        exp_reg(A_STAT, 32'd1, "R5");
        wr(A_STAT, 32'd0); m_flag = 1'b0;
        exp_reg(A_STAT, 32'd0, "R5");

        // R4 hold while stopped, resume from held prescaler count
        run_edges(2);
        exp_reg(A_CNT, m_cnt, "R4");
        repeat (20) @(posedge clk);
        exp_reg(A_CNT, m_cnt, "R4");
        run_edges(3);
        exp_reg(A_CNT, m_cnt, "R4");

        // R7 interrupt level
        wr(A_IEN, 32'd1);
        exp_irq(1'b0, "R7");
        wr(A_PSC, 32'd0); m_p = 0;
        run_edges(1);
        wr(A_CNT, 32'd4); m_cnt = 4;
        wr(A_STAT, 32'd0); m_flag = 1'b0;
        run_edges(1);
        exp_irq(1'b1, "R7");
        wr(A_IEN, 32'd0);
        exp_irq(1'b0, "R7");
        exp_reg(A_STAT, 32'd1, "R7");
        wr(A_IEN, 32'd1);
        exp_irq(1'b1, "R7");
        wr(A_STAT, 32'd0); m_flag = 1'b0;
        exp_irq(1'b0, "R7");

        // R6 clear lands on the update edge; set must win
        wr(A_LIM, 32'd3); m_l = 3;
        wr(A_CNT, 32'd3); m_cnt = 3;
        wr(A_RUN, 32'd1);
        wr(A_STAT, 32'd0);
        wr(A_RUN, 32'd0);
        model_step(); model_step();
        exp_reg(A_STAT, 32'd1, "R6");
        exp_reg(A_CNT, 32'd1, "R6");
        exp_irq(1'b1, "R6");

        // R9 counter above limit wraps on next step
        wr(A_IEN, 32'd0);
        wr(A_STAT, 32'd0); m_flag = 1'b0;
        wr(A_CNT, 32'd9); m_cnt = 9;
        run_edges(1);
        exp_reg(A_CNT, 32'd0, "R9");
        exp_reg(A_STAT, 32'd1, "R9");
        // R9 prescaler count above lowered divisor wraps next cycle
        wr(A_PSC, 32'd7); m_p = 7;
        run_edges(5);
        wr(A_PSC, 32'd2); m_p = 2;
        run_edges(1);
        exp_reg(A_CNT, 32'd1, "R9");
        exp_reg(A_CNT, m_cnt, "R9");

        // R10 unmapped offsets
        wr(8'h18, 32'hFFFFFFFF);
        wr(8'h02, 32'hFFFFFFFF);
        exp_reg(8'h18, 32'd0, "R10");
        exp_reg(8'h02, 32'd0, "R10");
        exp_reg(A_LIM, 32'd3, "R10");
        exp_reg(A_PSC, 32'd2, "R10");
        exp_reg(A_RUN, 32'd0, "R10");

        // R3 full period of (9+1)*(19+1) = 200 cycles
        wr(A_PSC, 32'd0); m_p = 0;
        run_edges(1);
        wr(A_PSC, 32'd9); m_p = 9;
        wr(A_LIM, 32'd19); m_l = 19;
        wr(A_CNT, 32'd0); m_cnt = 0;
        wr(A_STAT, 32'd0); m_flag = 1'b0;
        run_edges(199);
        exp_reg(A_STAT, 32'd0, "R3");
        exp_reg(A_CNT, 32'd19, "R3");
        run_edges(1);
        exp_reg(A_STAT, 32'd1, "R3");
        exp_reg(A_CNT, 32'd0, "R3");
        exp_reg(A_STAT, {31'd0, m_flag}, "R3");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule